// File: doc/BRIEF.md
# Network Controller Register Bank

This block is the host-visible register file of a network controller. It holds 64 word-wide (16-bit) locations behind a simple synchronous port: address, write enable, write data, read enable and read data. Reads return one cycle after the read enable. Each location follows its own write rule. Some are plain storage and some keep only certain bits. Some store the inverse of what is written, some accept writes only while the controller is held in reset, and some are read-only.

A command word at address 0x00 turns host writes into one-cycle action strobes for the rest of the core. These strobes cover halting or starting transmission, turning the receiver on or off, starting or stopping the timer, software reset, fetching the next receive resource and loading the address filter. Core logic reports completed actions on a clear bus, which drops the matching command bits. Status events from the core raise interrupt-status bits through set pulses. A registered interrupt line follows the masked status. The actions themselves live outside this block.

Address map used throughout: 0x00 command, 0x01 interrupt status, 0x02 interrupt mask, 0x03 data configuration, 0x04 second configuration, 0x05 transmit control, 0x06 receive control, 0x08..0x0B ring start/end/read/write pointers, 0x0C end-of-buffer count, 0x10..0x12 error tallies, 0x13 silicon revision. Every other address is plain 16-bit storage.

Top module: `nic_regbank`

## Requirements
- R1: `irq` is a register. It is high one cycle after the interrupt mask AND the interrupt status is non-zero, and low one cycle after it becomes zero.
- R2: A write to the mask (0x02) stores only bits 14:0. Bit 15 always reads 0 and never contributes to `irq`.
- R3: The status register (0x01) is write-one-to-clear. Writing 1 to bit 5 while it is set clears it and pulses `act_strobe[8]` one cycle later. Writing it while it is already clear gives no strobe.
- R4: Writes to the four ring pointers (0x08..0x0B) store the data with bit 0 forced to 0.
- R5: The three error tallies (0x10..0x12) store the bitwise inverse of the written data.
- R6: Transmit control (0x05) keeps written bits 15:12 only. Receive control (0x06) keeps bits 15:5 only.
- R7: Data configuration (0x03, mask 0xBFFF) and second configuration (0x04, mask 0xF017) take writes only while command bit 7 is set. Otherwise they are left unchanged.
- R8: While command bit 7 is set, a command write without bit 7 only clears bit 7. All action strobes stay low.
- R9: Command bits are: 0 halt, 1 transmit, 2 receiver off, 3 receiver on, 4 timer stop, 5 timer start, 7 software reset, 8 resource fetch, 9 filter load. An accepted command write ORs `data & 0x03BF` into the command word, and `act_strobe` equals `data[9:0] & 0x3BF` for exactly one cycle. A written bit 2 clears bit 3, a written bit 3 clears bit 2, a written bit 4 clears bit 5, and a written bit 5 clears bit 4.
- R10: After `rst`, the command word reads 0x0094, the end-of-buffer count reads 0x02F8, and the mask, status, `irq` and strobes are zero.
- R11: The revision register (0x13) reads 0x0004, and writes to it are ignored.
- R12: An accepted command write with bit 7 set ends with bits 9, 8, 1 and 0 clear and bits 7 and 2 set. This is applied after the other rules of R9.
- R13: A status set pulse wins over a host clear of the same bit in the same cycle.
- R14: A 1 on `act_done[i]` clears command bit i on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_addr | input | ADDR_W | Word address |
| host_we | input | 1 | Write enable |
| host_wdata | input | 16 | Write data |
| host_re | input | 1 | Read enable |
| host_rdata | output | 16 | Read data, valid the cycle after `host_re` |
| stat_set | input | 16 | Per-bit status set pulses from the core |
| act_done | input | 10 | Per-bit command completion clears from the core |
| act_strobe | output | 10 | One-cycle action strobes, indexed by command bit |
| irq | output | 1 | Registered interrupt level |

## Verification
Two functions can hit the interrupt status in the same cycle: a set pulse from the core and a host write-one-to-clear of the same bit. The bench drives both on one clock edge. It then expects the bit to stay set while the other written bits clear, and checks the result through a read and through `irq` one cycle later. The command word has the same kind of overlap between host writes and completion clears. For that path, the bench relies on the completion clear landing on its own edge, and on the ordering of the leave-reset rule against a software reset.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

  localparam int DW      = 16;
  localparam int NACT    = 10;
  localparam int RB_BIT  = 5;   // status bit for receive resources exhausted
  localparam int FETCH_BIT = 8; // command bit for resource fetch

  localparam int A_CMD   = 'h00;
  localparam int A_ISTAT = 'h01;
  localparam int A_IMASK = 'h02;
  localparam int A_CFG1  = 'h03;
  localparam int A_CFG2  = 'h04;
  localparam int A_TXCTL = 'h05;
  localparam int A_RXCTL = 'h06;
  localparam int A_RSTART = 'h08;
  localparam int A_RWRITE = 'h0B;
  localparam int A_EOB   = 'h0C;
  localparam int A_TALLY0 = 'h10;
  localparam int A_TALLY2 = 'h12;
  localparam int A_REV   = 'h13;

  localparam logic [DW-1:0] CMD_RESET_VAL = 16'h0094;
  localparam logic [DW-1:0] CMD_WMASK     = 16'h03BF;

  typedef enum logic [2:0] {
    RK_PLAIN,   // full storage
    RK_MASKED,  // storage with fixed write mask
    RK_INV,     // stores inverted data
    RK_CFG,     // writable only while in reset mode
    RK_RO,      // constant, writes dropped
    RK_EXT      // owned by another unit
  } rkind_t;

  function automatic rkind_t kind_of(input int a);
    if (a == A_CMD || a == A_ISTAT || a == A_IMASK) return RK_EXT;
    if (a == A_CFG1 || a == A_CFG2)                 return RK_CFG;
    if (a == A_TXCTL || a == A_RXCTL)               return RK_MASKED;
    if (a >= A_RSTART && a <= A_RWRITE)             return RK_MASKED;
    if (a >= A_TALLY0 && a <= A_TALLY2)             return RK_INV;
    if (a == A_REV)                                 return RK_RO;
    return RK_PLAIN;
  endfunction

  function automatic logic [DW-1:0] wmask_of(input int a);
    if (a == A_CFG1)                     return 16'hBFFF;
    if (a == A_CFG2)                     return 16'hF017;
    if (a == A_TXCTL)                    return 16'hF000;
    if (a == A_RXCTL)                    return 16'hFFE0;
    if (a >= A_RSTART && a <= A_RWRITE)  return 16'hFFFE;
    return 16'hFFFF;
  endfunction

endpackage

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_regbank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [15:0] REV_ID = 16'h0004,
  parameter logic [15:0] EOB_RESET = 16'h02F8,
  localparam int NREG = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     cfg_open,
  output logic [NREG-1:0][DW-1:0]  rf_q
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam rkind_t K = kind_of(i);
    localparam logic [DW-1:0] M = wmask_of(i);
    localparam logic [DW-1:0] RV = (i == A_EOB) ? EOB_RESET : '0;

    if (K == RK_EXT) begin : g_ext
      assign rf_q[i] = '0;
    end else if (K == RK_RO) begin : g_ro
      assign rf_q[i] = (i == A_REV) ? REV_ID : '0;
    end else begin : g_st
      logic hit;
      logic [DW-1:0] q;
      assign hit = we && (waddr == ADDR_W'(i)) && ((K != RK_CFG) || cfg_open);
      always_ff @(posedge clk) begin
        if (rst)      q <= RV;
        else if (hit) q <= (K == RK_INV) ? ~wdata : (wdata & M);
      end
      assign rf_q[i] = q;
    end
  end

endmodule

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
  import nic_regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic [NACT-1:0] done,
  output logic [DW-1:0]   cmd_q,
  output logic [NACT-1:0] strobe_q
);

  logic [DW-1:0]   cmd_n;
  logic [NACT-1:0] strobe_n;
  logic [DW-1:0]   acc;

  always_comb begin
    cmd_n    = cmd_q & ~{{(DW-NACT){1'b0}}, done};
    strobe_n = '0;
    acc      = wdata & CMD_WMASK;
    if (wr) begin
      if (cmd_q[7] && !wdata[7]) begin
        // leaving reset mode: nothing else happens
        cmd_n[7] = 1'b0;
      end else begin
        cmd_n    = cmd_n | acc;
        strobe_n = acc[NACT-1:0];
        if (acc[2]) cmd_n[3] = 1'b0;
        if (acc[3]) cmd_n[2] = 1'b0;
        if (acc[4]) cmd_n[5] = 1'b0;
        if (acc[5]) cmd_n[4] = 1'b0;
        if (acc[7]) begin
          cmd_n[9:8] = 2'b00;
          cmd_n[1:0] = 2'b00;
          cmd_n[7]   = 1'b1;
          cmd_n[2]   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= CMD_RESET_VAL;
      strobe_q <= '0;
    end else begin
      cmd_q    <= cmd_n;
      strobe_q <= strobe_n;
    end
  end

endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_wr,
  input  logic          stat_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_set,
  output logic [DW-2:0] imask_q,
  output logic [DW-1:0] istat_q,
  output logic          fetch_q,
  output logic          irq_q
);

  logic [DW-1:0] clr;

  assign clr = stat_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      imask_q <= '0;
      istat_q <= '0;
      fetch_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (mask_wr) imask_q <= wdata[DW-2:0];
      istat_q <= (istat_q & ~clr) | stat_set;
      fetch_q <= clr[RB_BIT] & istat_q[RB_BIT];
      irq_q   <= |({1'b0, imask_q} & istat_q);
    end
  end

endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [15:0] REV_ID = 16'h0004,
  parameter logic [15:0] EOB_RESET = 16'h02F8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [15:0]       host_wdata,
  input  logic              host_re,
  output logic [15:0]       host_rdata,
  input  logic [15:0]       stat_set,
  input  logic [9:0]        act_done,
  output logic [9:0]        act_strobe,
  output logic              irq
);

  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0][DW-1:0] rf_q;
  logic [DW-1:0]   cmd_q;
  logic [NACT-1:0] cmd_strobe;
  logic [DW-2:0]   imask_q;
  logic [DW-1:0]   istat_q;
  logic            fetch_q;
  logic            cmd_wr, mask_wr, stat_wr;

  assign cmd_wr  = host_we && (host_addr == ADDR_W'(A_CMD));
  assign mask_wr = host_we && (host_addr == ADDR_W'(A_IMASK));
  assign stat_wr = host_we && (host_addr == ADDR_W'(A_ISTAT));

  nic_cmd_unit u_cmd (
    .clk      (clk),
    .rst      (rst),
    .wr       (cmd_wr),
    .wdata    (host_wdata),
    .done     (act_done),
    .cmd_q    (cmd_q),
    .strobe_q (cmd_strobe)
  );

  nic_irq_unit u_irq (
    .clk      (clk),
    .rst      (rst),
    .mask_wr  (mask_wr),
    .stat_wr  (stat_wr),
    .wdata    (host_wdata),
    .stat_set (stat_set),
    .imask_q  (imask_q),
    .istat_q  (istat_q),
    .fetch_q  (fetch_q),
    .irq_q    (irq)
  );

  nic_regfile #(
    .ADDR_W    (ADDR_W),
    .REV_ID    (REV_ID),
    .EOB_RESET (EOB_RESET)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (host_we),
    .waddr    (host_addr),
    .wdata    (host_wdata),
    .cfg_open (cmd_q[7]),
    .rf_q     (rf_q)
  );

  // fetch request from the status clear path merges onto the fetch strobe
  assign act_strobe = cmd_strobe | (NACT'(fetch_q) << FETCH_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      if (host_addr == ADDR_W'(A_CMD))        host_rdata <= cmd_q;
      else if (host_addr == ADDR_W'(A_ISTAT)) host_rdata <= istat_q;
      else if (host_addr == ADDR_W'(A_IMASK)) host_rdata <= {1'b0, imask_q};
      else                                    host_rdata <= rf_q[host_addr];
    end
  end

endmodule

// File: rtl/nic_regbank_chk.sv
module nic_regbank_chk
  import nic_regbank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [15:0] REV_ID = 16'h0004
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_we,
  input logic [15:0]       host_wdata,
  input logic              host_re,
  input logic [15:0]       host_rdata,
  input logic [15:0]       stat_set,
  input logic [9:0]        act_done,
  input logic [9:0]        act_strobe,
  input logic              irq,
  input logic [15:0]       cmd_q,
  input logic [14:0]       imask_q,
  input logic [15:0]       istat_q
);

  p_irq_level_r1: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|({1'b0, imask_q} & istat_q)));

  p_mask_drop_r2: assert property (@(posedge clk) disable iff (rst)
    host_we && host_addr == ADDR_W'(A_IMASK) |=> imask_q == $past(host_wdata[14:0]));

  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    host_we && host_addr == ADDR_W'(A_ISTAT) && stat_set == 16'h0
      |=> istat_q == ($past(istat_q) & ~$past(host_wdata)));

  p_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    host_we && host_addr == ADDR_W'(A_ISTAT) && host_wdata[RB_BIT] && istat_q[RB_BIT]
      |=> act_strobe[FETCH_BIT]);

  p_leave_reset_r8: assert property (@(posedge clk) disable iff (rst)
    host_we && host_addr == ADDR_W'(A_CMD) && cmd_q[7] && !host_wdata[7] && act_done == 10'h0
      |=> cmd_q == ($past(cmd_q) & 16'hFF7F) && act_strobe == 10'h0);

  p_soft_reset_r12: assert property (@(posedge clk) disable iff (rst)
    host_we && host_addr == ADDR_W'(A_CMD) && host_wdata[7] && act_done == 10'h0
      |=> cmd_q[7] && cmd_q[2] && cmd_q[9:8] == 2'b00 && cmd_q[1:0] == 2'b00);

  p_set_wins_r13: assert property (@(posedge clk) disable iff (rst)
    stat_set != 16'h0 |=> (istat_q & $past(stat_set)) == $past(stat_set));

  p_rev_const_r11: assert property (@(posedge clk) disable iff (rst)
    host_re && host_addr == ADDR_W'(A_REV) |=> host_rdata == REV_ID);

endmodule

bind nic_regbank nic_regbank_chk #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_we    (host_we),
  .host_wdata (host_wdata),
  .host_re    (host_re),
  .host_rdata (host_rdata),
  .stat_set   (stat_set),
  .act_done   (act_done),
  .act_strobe (act_strobe),
  .irq        (irq),
  .cmd_q      (cmd_q),
  .imask_q    (imask_q),
  .istat_q    (istat_q)
);

// File: tb/nic_regbank_test.sv
module nic_regbank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  host_addr;
  logic        host_we, host_re;
  logic [15:0] host_wdata, host_rdata, stat_set;
  logic [9:0]  act_done, act_strobe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  nic_regbank uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_re(host_re), .host_rdata(host_rdata),
    .stat_set(stat_set), .act_done(act_done), .act_strobe(act_strobe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read enable
  always @(posedge clk) pend <= host_re;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) chk(host_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    host_addr = a; host_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic wrs(input logic [5:0] a, input logic [15:0] d, input logic [15:0] s);
    host_addr = a; host_wdata = d; host_we = 1'b1; stat_set = s;
    @(negedge clk);
    host_we = 1'b0; stat_set = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    wrs(a, d, 16'h0);
  endtask

  task automatic setp(input logic [15:0] s);
    stat_set = s;
    @(negedge clk);
    stat_set = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; host_addr = '0; host_we = 1'b0; host_re = 1'b0;
    host_wdata = '0; stat_set = '0; act_done = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({15'h0, irq}, 16'h0, "R10 irq after reset");
    chk({6'h0, act_strobe}, 16'h0, "R10 strobes after reset");
    rd(6'h00, 16'h0094, "R10 command reset value");
    rd(6'h0C, 16'h02F8, "R10 end-of-buffer reset value");
    rd(6'h02, 16'h0000, "R10 mask reset value");
    rd(6'h01, 16'h0000, "R10 status reset value");
    rd(6'h13, 16'h0004, "R11 revision value");

    wr(6'h03, 16'hFFFF); rd(6'h03, 16'hBFFF, "R7 cfg1 write in reset");
    wr(6'h04, 16'hFFFF); rd(6'h04, 16'hF017, "R7 cfg2 write in reset");

    wr(6'h00, 16'h0008);
    chk({6'h0, act_strobe}, 16'h0, "R8 no strobe on reset exit");
    rd(6'h00, 16'h0014, "R8 reset exit only clears bit 7");
    wr(6'h03, 16'h1234); rd(6'h03, 16'hBFFF, "R7 cfg1 locked outside reset");
    wr(6'h04, 16'h0000); rd(6'h04, 16'hF017, "R7 cfg2 locked outside reset");

    wr(6'h00, 16'h0002);
    chk({6'h0, act_strobe}, 16'h0002, "R9 transmit strobe");
    @(negedge clk);
    chk({6'h0, act_strobe}, 16'h0000, "R9 strobe lasts one cycle");
    rd(6'h00, 16'h0016, "R9 transmit bit ORed");
    wr(6'h00, 16'h0008);
    chk({6'h0, act_strobe}, 16'h0008, "R9 receiver-on strobe");
    rd(6'h00, 16'h001A, "R9 receiver-on clears receiver-off");
    wr(6'h00, 16'h0020);
    rd(6'h00, 16'h002A, "R9 timer start clears timer stop");

    act_done = 10'h002; @(negedge clk); act_done = '0;
    rd(6'h00, 16'h0028, "R14 completion clears transmit bit");

    wr(6'h00, 16'h0183);
    chk({6'h0, act_strobe}, 16'h0183, "R12 strobes on software reset write");
    rd(6'h00, 16'h00AC, "R12 software reset result");

    wr(6'h13, 16'hFFFF); rd(6'h13, 16'h0004, "R11 revision write ignored");
    wr(6'h08, 16'hABCD); rd(6'h08, 16'hABCC, "R4 ring start bit0");
    wr(6'h0B, 16'h0001); rd(6'h0B, 16'h0000, "R4 ring write bit0");
    wr(6'h10, 16'h1234); rd(6'h10, 16'hEDCB, "R5 tally inverted");
    wr(6'h12, 16'h0000); rd(6'h12, 16'hFFFF, "R5 tally inverted zero");
    wr(6'h05, 16'hFFFF); rd(6'h05, 16'hF000, "R6 transmit control mask");
    wr(6'h06, 16'hFFFF); rd(6'h06, 16'hFFE0, "R6 receive control mask");
    wr(6'h02, 16'hFFFF); rd(6'h02, 16'h7FFF, "R2 mask bit 15 dropped");
    chk({15'h0, irq}, 16'h0, "R1 irq low with empty status");

    setp(16'h0020);
    chk({15'h0, irq}, 16'h0, "R1 irq registered one cycle late");
    @(negedge clk);
    chk({15'h0, irq}, 16'h1, "R1 irq high after status set");
    setp(16'h8000);
    rd(6'h01, 16'h8020, "R13 status set pulses accumulate");

    wr(6'h01, 16'h0020);
    chk({6'h0, act_strobe}, 16'h0100, "R3 clearing exhausted bit fetches");
    @(negedge clk);
    chk({15'h0, irq}, 16'h0, "R2 status bit 15 never interrupts");
    rd(6'h01, 16'h8000, "R3 only written bit cleared");
    wr(6'h01, 16'h0020);
    chk({6'h0, act_strobe}, 16'h0000, "R3 no fetch when bit already clear");

    setp(16'h0001);
    wrs(6'h01, 16'h8001, 16'h0001);
    rd(6'h01, 16'h0001, "R13 set wins over same-cycle clear");
    chk({15'h0, irq}, 16'h1, "R13 irq stays high through set-wins");

    wr(6'h00, 16'h0000);
    chk({6'h0, act_strobe}, 16'h0, "R8 zero write only leaves reset");
    rd(6'h00, 16'h002C, "R8 leave reset again");
    wr(6'h00, 16'h0010);
    chk({6'h0, act_strobe}, 16'h0010, "R9 timer stop strobe");
    rd(6'h00, 16'h001C, "R9 timer stop clears timer start");

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule